// File: doc/BRIEF.md
# Period-Synchronous Dual-Edge Capture Unit

This block timestamps the edges of an already synchronised input signal against a free-running counter. Every rising edge loads the counter value into a pending rising capture. Every falling edge loads it into a pending falling capture. Within a measurement period a later edge of the same kind overwrites an earlier one. When the period-end strobe arrives, each pending capture that was filled during the period moves into its published register: register A holds the rising capture and register B holds the falling capture. An edge kind that did not occur leaves its published value as it was.

The published registers are wider than the 8-bit read bus, so a processor reads them as a low byte and a high byte. Without protection, a period end could change the registers in the middle of that sequence. Reading either low byte therefore raises a lock. Reading the high byte of B drops it. While the lock is raised, period-end transfers are skipped. The pending captures are kept and go out at the first period end that finds the lock clear. Reading A on its own never drops the lock. Reading B on its own, low byte first, is a complete sequence.

Top module: `edge_period_capture`

## Requirements
- R1: After reset, all four byte addresses read 0x00 and the lock is clear, so the first period end with captured edges publishes them.
- R2: Edge detection compares the present input with its value at the previous clock edge; that stored value is 0 after reset. A 0-to-1 change at a clock edge loads `cnt_val` into the pending rising capture. A 1-to-0 change loads it into the pending falling capture.
- R3: At a clock edge with `period_end` high and the lock clear, each pending capture that was loaded since its last transfer is copied into its published register (rising to A, falling to B). The new value is readable from the next cycle.
- R4: When several edges of one kind occur before a transfer, the value from the last of them is published.
- R5: A published register whose edge kind did not occur since its last transfer keeps its value at a period end. The per-kind "loaded" flag clears at each transfer.
- R6: Reads are combinational while `rd_en` is high. Address 0 returns A[7:0], address 1 returns the high byte of A, address 2 returns B[7:0] and address 3 returns the high byte of B. When `rd_en` is low, `rd_data` is 0x00.
- R7: In a high-byte read, bits 7 to 2 are always 0 and bits 1 to 0 carry capture bits 9 to 8.
- R8: A read of address 0 or 2 sets the lock. While the lock is set, a period end leaves A and B unchanged, and the pending captures are kept for a later transfer.
- R9: Only a read of address 3 clears the lock. Reading addresses 0 and 1 alone leaves the registers locked.
- R10: The sequence address 2 then address 3, with A never read, locks and then releases the registers.
- R11: An edge detected in the same clock edge as a transfer belongs to the next period. The transfer publishes the earlier pending value, and the new edge is published at the following period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_in | input | 1 | Synchronised signal whose edges are captured |
| cnt_val | input | CAP_W (10) | Free-running counter value to capture |
| period_end | input | 1 | Period-end strobe, one cycle |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Byte address: 0/1 = A low/high, 2/3 = B low/high |
| rd_data | output | BYTE_W (8) | Read data, combinational |

## Verification
The bench builds the block with its default widths: a 10-bit capture and an 8-bit bus. With these widths, every high-byte read has six bits that must be zero and two bits that carry data. The capture values 0x155, 0x2AA and 0x3FF are chosen so that both the low and the high bytes show alternating and saturated bit patterns. Directed edge sequences cover last-edge-wins, hold with no edge, edges coinciding with the period strobe, and skipped transfers while locked in both the A-only and the B-only read orders.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned CAP_W_DEF  = 10;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned ADDR_W     = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A_LO = 2'd0,
    SEL_A_HI = 2'd1,
    SEL_B_LO = 2'd2,
    SEL_B_HI = 2'd3
  } sel_e;

  // A low-byte read of either register opens a read sequence.
  function automatic logic opens_seq(sel_e s);
    return (s == SEL_A_LO) || (s == SEL_B_LO);
  endfunction

  // Only the high byte of B closes the sequence.
  function automatic logic closes_seq(sel_e s);
    return s == SEL_B_HI;
  endfunction
endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_in,
  output logic rise_o,
  output logic fall_o
);
  logic sample_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_q <= 1'b0;
    else        sample_q <= sample_in;
  end

  assign rise_o = sample_in & ~sample_q;
  assign fall_o = ~sample_in & sample_q;

  // R2: the two edge kinds never coincide
  a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
  // R2: after a rising edge the stored sample is high
  a_r2_rise_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> sample_q);
  // R2: after a falling edge the stored sample is low
  a_r2_fall_then_low: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !sample_q);
endmodule

// File: rtl/cap_edge_slot.sv
module cap_edge_slot #(
  parameter int unsigned CAP_W = cap_pkg::CAP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [CAP_W-1:0] cnt_val,
  input  logic             xfer,
  output logic [CAP_W-1:0] pub_o
);
  logic [CAP_W-1:0] pending_q;
  logic             loaded_q;
  logic             publish;

  assign publish = xfer & loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      loaded_q  <= 1'b0;
      pub_o     <= '0;
    end else begin
      if (hit)          pending_q <= cnt_val;
      if (hit)          loaded_q  <= 1'b1;
      else if (xfer)    loaded_q  <= 1'b0;
      if (publish)      pub_o     <= pending_q;
    end
  end

  // R3 / R4: a transfer publishes the pending value held before that edge
  a_r3_publish_pending: assert property (@(posedge clk) disable iff (!rst_n)
    publish |=> (pub_o == $past(pending_q)));
  // R5: no edge since the last transfer keeps the published value
  a_r5_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !loaded_q) |=> $stable(pub_o));
  // R5: the loaded flag clears after a transfer without a new edge
  a_r5_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !hit) |=> !loaded_q);
  // R11: an edge in the transfer cycle stays pending for the next period
  a_r11_edge_next_period: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && hit) |=> loaded_q);
endmodule

// File: rtl/cap_read_port.sv
module cap_read_port
  import cap_pkg::*;
#(
  parameter int unsigned CAP_W  = CAP_W_DEF,
  parameter int unsigned BYTE_W = BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CAP_W-1:0]  pub_a,
  input  logic [CAP_W-1:0]  pub_b,
  output logic [BYTE_W-1:0] rd_data,
  output logic              locked_o
);
  localparam int unsigned WIDE_W = 2 * BYTE_W;
  localparam int unsigned HI_W   = CAP_W - BYTE_W;

  sel_e sel;
  logic opens, closes;

  // Byte slice of a capture, zero-extended to two bus bytes.
  function automatic logic [BYTE_W-1:0] byte_pick(logic [CAP_W-1:0] v, logic hi);
    logic [WIDE_W-1:0] wide;
    wide = {{(WIDE_W-CAP_W){1'b0}}, v};
    return hi ? wide[WIDE_W-1:BYTE_W] : wide[BYTE_W-1:0];
  endfunction

  assign sel    = sel_e'(rd_addr);
  assign opens  = rd_en & opens_seq(sel);
  assign closes = rd_en & closes_seq(sel);

  always_comb begin
    rd_data = '0;
    if (rd_en) rd_data = byte_pick(rd_addr[1] ? pub_b : pub_a, rd_addr[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      locked_o <= 1'b0;
    else if (opens)  locked_o <= 1'b1;
    else if (closes) locked_o <= 1'b0;
  end

  // R7: the unused top bits of a high-byte read are zero
  always_comb begin
    if (rst_n && rd_en && rd_addr[0])
      a_r7_hi_zero: assert (rd_data[BYTE_W-1:HI_W] == '0);
  end
  // R6: no read strobe, no data
  always_comb begin
    if (rst_n && !rd_en)
      a_r6_idle_zero: assert (rd_data == '0);
  end
  // R8: a low-byte read leaves the registers locked
  a_r8_lo_locks: assert property (@(posedge clk) disable iff (!rst_n)
    opens |=> locked_o);
  // R9: the high byte of B releases the lock
  a_r9_bhi_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    closes |=> !locked_o);
  // R9: the high byte of A does not release the lock
  a_r9_ahi_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && rd_en && sel == SEL_A_HI) |=> locked_o);
endmodule

// File: rtl/edge_period_capture.sv
module edge_period_capture
  import cap_pkg::*;
#(
  parameter int unsigned CAP_W  = CAP_W_DEF,
  parameter int unsigned BYTE_W = BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_in,
  input  logic [CAP_W-1:0]  cnt_val,
  input  logic              period_end,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int unsigned N_KIND = 2; // index 0 rising -> A, 1 falling -> B

  logic             rise_ev, fall_ev;
  logic             locked;
  logic             xfer_ev;
  logic [N_KIND-1:0] hit_ev;
  logic [CAP_W-1:0] pub_val [N_KIND];

  cap_edge_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_in (cap_in),
    .rise_o    (rise_ev),
    .fall_o    (fall_ev)
  );

  assign hit_ev  = {fall_ev, rise_ev};
  assign xfer_ev = period_end & ~locked;

  for (genvar g = 0; g < N_KIND; g++) begin : g_slot
    cap_edge_slot #(.CAP_W(CAP_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit_ev[g]),
      .cnt_val (cnt_val),
      .xfer    (xfer_ev),
      .pub_o   (pub_val[g])
    );
  end

  cap_read_port #(.CAP_W(CAP_W), .BYTE_W(BYTE_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .pub_a    (pub_val[0]),
    .pub_b    (pub_val[1]),
    .rd_data  (rd_data),
    .locked_o (locked)
  );

  // R8: a period end during a locked read sequence changes nothing visible
  a_r8_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && period_end) |=> ($stable(pub_val[0]) && $stable(pub_val[1])));
  // R3: published values only move at a period end
  a_r3_move_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_ev |=> ($stable(pub_val[0]) && $stable(pub_val[1])));
endmodule

// File: tb/edge_period_capture_test.sv
`timescale 1ns/1ps
module edge_period_capture_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_in = 1'b0;
  logic [9:0] cnt_val = '0;
  logic       period_end = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  edge_period_capture uut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .cnt_val(cnt_val),
    .period_end(period_end), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // one clock: apply inputs at a falling edge, return at the next falling edge
  task automatic step(input logic c, input logic [9:0] cnt, input logic pe);
    cap_in = c; cnt_val = cnt; period_end = pe;
    @(negedge clk);
    period_end = 1'b0;
  endtask

  task automatic rise(input logic [9:0] cnt); step(1'b1, cnt, 1'b0); endtask
  task automatic fall(input logic [9:0] cnt); step(1'b0, cnt, 1'b0); endtask
  task automatic pend(); step(cap_in, cnt_val, 1'b1); endtask

  task automatic chk_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    rd_en = 1'b1; rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      failures++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rd_data, exp);
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // full A-then-B read; leaves the lock released
  task automatic chk_regs(input logic [9:0] ea, input logic [9:0] eb, input string req);
    chk_rd(2'd0, ea[7:0], req);
    chk_rd(2'd1, 8'(ea >> 8), req);
    chk_rd(2'd2, eb[7:0], req);
    chk_rd(2'd3, 8'(eb >> 8), req);
  endtask

  task automatic t_reset();
    chk_regs(10'h000, 10'h000, "R1_reset");
  endtask

  task automatic t_basic();
    rise(10'h155); fall(10'h2AA); pend();
    chk_regs(10'h155, 10'h2AA, "R2_R3_R6_R7_basic");
  endtask

  task automatic t_last_wins();
    rise(10'h010); fall(10'h020); rise(10'h123); fall(10'h3FF); pend();
    chk_regs(10'h123, 10'h3FF, "R4_last_wins");
  endtask

  task automatic t_hold();
    rise(10'h0AB); pend();
    chk_regs(10'h0AB, 10'h3FF, "R5_hold_fall");
    pend();
    chk_regs(10'h0AB, 10'h3FF, "R5_hold_both");
    fall(10'h0FF); pend();
    chk_regs(10'h0AB, 10'h0FF, "R5_hold_rise");
  endtask

  task automatic t_lock_a_only();
    chk_rd(2'd0, 8'hAB, "R8_lock_open");
    rise(10'h200); fall(10'h201); pend();
    chk_rd(2'd1, 8'h00, "R8_locked_a_hi");
    chk_rd(2'd2, 8'hFF, "R8_locked_b_lo");
    pend();
    chk_rd(2'd2, 8'hFF, "R9_a_only_still_locked");
    chk_rd(2'd3, 8'h00, "R9_release");
    pend();
    chk_regs(10'h200, 10'h201, "R8_pending_kept");
  endtask

  task automatic t_b_only();
    rise(10'h0C3); fall(10'h13C); pend();
    chk_rd(2'd2, 8'h3C, "R10_b_lo");
    rise(10'h111); pend();
    chk_rd(2'd2, 8'h3C, "R10_locked_skip");
    chk_rd(2'd3, 8'h01, "R10_b_hi");
    pend();
    chk_regs(10'h111, 10'h13C, "R10_released");
  endtask

  task automatic t_same_cycle();
    fall(10'h060); rise(10'h050);
    step(1'b0, 10'h070, 1'b1);
    chk_regs(10'h050, 10'h060, "R11_strobe_edge_old");
    pend();
    chk_regs(10'h050, 10'h070, "R11_strobe_edge_next");
  endtask

  task automatic t_idle();
    rd_en = 1'b0; rd_addr = 2'd0;
    #1;
    checks++;
    if (rd_data !== 8'h00) begin
      failures++;
      $display("FAIL R6_idle actual=%h expected=00", rd_data);
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_last_wins();
    t_hold();
    t_lock_a_only();
    t_b_only();
    t_same_cycle();
    t_idle();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule